// File: doc/BRIEF.md
# Twisted Ring Counter with Two-Input State Decode

This block is a synchronous twisted-ring counter. A chain of flip-flops shifts by one place on every enabled rising clock edge, and an inverting feedback term sets the top stage. The feedback is chosen when the block is built. The plain form feeds back the complement of the bottom stage and runs through `2*STAGES` states. The odd form feeds back the NOR of the two bottom stages. This drops the all-ones pattern from the loop and leaves `2*STAGES-1` states.

The block drives the raw stage vector. It also drives a one-hot vector with one bit for each legal state. Each decode bit is a single two-input AND of two stage bits, with either input optionally inverted. The block suits sequencing and phase generation, where a downstream unit needs one qualified strobe per step and cannot afford a wide comparator.

Top module: `twisted_ring_counter`

## Requirements
- R1: When `rst` is high at a rising edge, every stage clears. After that edge, `stage_q` is all zeros and `state_hot` equals 1, meaning only bit 0 is set.
- R2: `rst` takes priority over `count_en`. An edge with both inputs high gives the R1 result.
- R3: At an edge where `rst` is low and `count_en` is low, `stage_q` and `state_hot` keep their values.
- R4: At an edge where `count_en` is high and `rst` is low, the chain shifts toward stage 0. The new `stage_q[i]` equals the old `stage_q[i+1]` for every i below `STAGES-1`, and all stages change on the same edge.
- R5: With `ODD_MODULUS=0`, the new top stage is the inverse of the old `stage_q[0]`. From zero the counter visits `2*STAGES` distinct states, then returns to zero. For `STAGES=4` the order is 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001.
- R6: With `ODD_MODULUS=1`, the new top stage is high only when the old `stage_q[1]` and `stage_q[0]` are both low. The counter visits `2*STAGES-1` states, and the all-ones pattern never appears.
- R7: `state_hot` has one bit per legal state. Bit k is high exactly when the counter holds the k-th state reached from zero, where zero is state 0.
- R8: Whenever the counter holds a legal state, exactly one bit of `state_hot` is high.
- R9: After the last state of the sequence, one more enabled edge returns the counter to all zeros, with `state_hot` bit 0 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, active high |
| count_en | input | 1 | Advance the sequence by one step |
| stage_q | output | STAGES | Stage vector; bit STAGES-1 is the top (fed) stage |
| state_hot | output | 2*STAGES or 2*STAGES-1 | One-hot decoded state |

## Verification
Reset and count enable can be asserted at the same edge, and they must not mix. The bench holds `count_en` high while it pulses `rst` in the middle of a walk. The collision passes only if the result is the cleared state with decode bit 0, and not an advanced or partially shifted pattern. The bench also checks that the sequence then restarts from step one, so it can tell a correct reset from a reset that cleared the stages but let one shift through.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef struct packed {
      int  tap_a;
      bit  inv_a;
      int  tap_b;
      bit  inv_b;
   } tap_pair_t;

   function automatic int modulus_of(input int stages, input bit odd_form);
      return odd_form ? (2 * stages - 1) : (2 * stages);
   endfunction

   // Chooses the two stage bits that single out sequence step k.
   function automatic tap_pair_t pair_for_step(input int stages, input bit odd_form, input int k);
      tap_pair_t p;
      int        zeros;
      if (k == 0) begin
         p.tap_a = stages - 1; p.inv_a = 1'b1;
         p.tap_b = 0;          p.inv_b = 1'b1;
      end else if (k < stages) begin
         p.tap_a = stages - k;     p.inv_a = 1'b0;
         p.tap_b = stages - k - 1; p.inv_b = 1'b1;
      end else if (!odd_form && k == stages) begin
         p.tap_a = stages - 1; p.inv_a = 1'b0;
         p.tap_b = 0;          p.inv_b = 1'b0;
      end else begin
         zeros   = odd_form ? (k - stages + 1) : (k - stages);
         p.tap_a = stages - zeros;     p.inv_a = 1'b1;
         p.tap_b = stages - zeros - 1; p.inv_b = 1'b0;
      end
      return p;
   endfunction

endpackage

// File: rtl/trc_feedback.sv
module trc_feedback #(
   parameter int STAGES      = 4,
   parameter bit ODD_MODULUS = 1'b0
) (
   input  logic [STAGES-1:0] stage_q,
   output logic              feed_bit
);
   generate
      if (ODD_MODULUS) begin : g_odd
         always_comb feed_bit = ~stage_q[0] & ~stage_q[1];
      end else begin : g_even
         always_comb feed_bit = ~stage_q[0];
      end
   endgenerate
endmodule

// File: rtl/trc_shift_chain.sv
module trc_shift_chain #(
   parameter int STAGES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              feed_bit,
   output logic [STAGES-1:0] stage_q
);
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic next_bit;
         if (i == STAGES - 1) begin : g_top
            always_comb next_bit = feed_bit;
         end else begin : g_inner
            always_comb next_bit = stage_q[i+1];
         end
         always_ff @(posedge clk) begin
            if (rst)           stage_q[i] <= 1'b0;
            else if (shift_en) stage_q[i] <= next_bit;
         end
      end
   endgenerate
endmodule

// File: rtl/trc_state_decoder.sv
module trc_state_decoder #(
   parameter int STAGES      = 4,
   parameter bit ODD_MODULUS = 1'b0,
   localparam int MODULUS    = trc_pkg::modulus_of(STAGES, ODD_MODULUS)
) (
   input  logic [STAGES-1:0]  stage_q,
   output logic [MODULUS-1:0] state_hot
);
   generate
      for (genvar k = 0; k < MODULUS; k++) begin : g_step
         localparam trc_pkg::tap_pair_t PAIR = trc_pkg::pair_for_step(STAGES, ODD_MODULUS, k);
         localparam int TAP_A = PAIR.tap_a;
         localparam int TAP_B = PAIR.tap_b;
         localparam bit INV_A = PAIR.inv_a;
         localparam bit INV_B = PAIR.inv_b;
         logic term_a;
         logic term_b;
         always_comb begin
            term_a       = stage_q[TAP_A] ^ INV_A;
            term_b       = stage_q[TAP_B] ^ INV_B;
            state_hot[k] = term_a & term_b;
         end
      end
   endgenerate
endmodule

// File: rtl/twisted_ring_counter.sv
module twisted_ring_counter #(
   parameter int STAGES      = 4,
   parameter bit ODD_MODULUS = 1'b0,
   localparam int MODULUS    = trc_pkg::modulus_of(STAGES, ODD_MODULUS)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               count_en,
   output logic [STAGES-1:0]  stage_q,
   output logic [MODULUS-1:0] state_hot
);
   generate
      if (STAGES < 3) begin : g_bad_stages
         $error("twisted_ring_counter: STAGES must be at least 3");
      end
   endgenerate

   logic feed_bit;

   trc_feedback #(.STAGES(STAGES), .ODD_MODULUS(ODD_MODULUS)) u_feedback (
      .stage_q  (stage_q),
      .feed_bit (feed_bit)
   );

   trc_shift_chain #(.STAGES(STAGES)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (count_en),
      .feed_bit (feed_bit),
      .stage_q  (stage_q)
   );

   trc_state_decoder #(.STAGES(STAGES), .ODD_MODULUS(ODD_MODULUS)) u_decode (
      .stage_q   (stage_q),
      .state_hot (state_hot)
   );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
   parameter int STAGES      = 4,
   parameter bit ODD_MODULUS = 1'b0,
   localparam int MODULUS    = trc_pkg::modulus_of(STAGES, ODD_MODULUS)
) (
   input logic               clk,
   input logic               rst,
   input logic               count_en,
   input logic [STAGES-1:0]  stage_q,
   input logic [MODULUS-1:0] state_hot
);
   logic seen_rst = 1'b0;
   always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

   // R1 and R2: a reset edge clears the chain, even with count_en high
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (stage_q == '0 && state_hot == MODULUS'(1)));

   a_r3_hold: assert property (@(posedge clk) disable iff (rst || !seen_rst)
      !count_en |=> $stable(stage_q));

   a_r4_shift: assert property (@(posedge clk) disable iff (rst || !seen_rst)
      count_en |=> stage_q[STAGES-2:0] == $past(stage_q[STAGES-1:1]));

   generate
      if (ODD_MODULUS) begin : g_odd_chk
         a_r6_odd_feed: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            count_en |=> stage_q[STAGES-1] == $past(~stage_q[0] & ~stage_q[1]));
         a_r6_no_all_ones: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            stage_q != '1);
      end else begin : g_even_chk
         a_r5_even_feed: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            count_en |=> stage_q[STAGES-1] == $past(~stage_q[0]));
      end
      for (genvar k = 0; k < MODULUS; k++) begin : g_adv
         a_r7_advance: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            (count_en && state_hot[k]) |=> state_hot[(k + 1) % MODULUS]);
      end
   endgenerate

   a_r8_one_hot: assert property (@(posedge clk) disable iff (rst || !seen_rst)
      $countones(state_hot) == 1);
endmodule

bind twisted_ring_counter trc_checker #(.STAGES(STAGES), .ODD_MODULUS(ODD_MODULUS)) u_trc_checker (
   .clk       (clk),
   .rst       (rst),
   .count_en  (count_en),
   .stage_q   (stage_q),
   .state_hot (state_hot)
);

// File: tb/twisted_ring_counter_bench.sv
module twisted_ring_counter_bench;
   logic clk = 1'b0;
   logic rst = 1'b0;
   logic count_en = 1'b0;

   logic [3:0] e_q;
   logic [7:0] e_hot;
   logic [4:0] o_q;
   logic [8:0] o_hot;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [3:0] me_q;
   int         me_k;
   logic [4:0] mo_q;
   int         mo_k;

   always #10 clk = ~clk;

   twisted_ring_counter #(.STAGES(4), .ODD_MODULUS(1'b0)) u_twisted_ring_counter (
      .clk(clk), .rst(rst), .count_en(count_en), .stage_q(e_q), .state_hot(e_hot));

   twisted_ring_counter #(.STAGES(5), .ODD_MODULUS(1'b1)) u_twisted_ring_counter_odd (
      .clk(clk), .rst(rst), .count_en(count_en), .stage_q(o_q), .state_hot(o_hot));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check({req, " even stages"}, 32'(e_q), 32'(me_q));
      check({req, " R7 even decode"}, 32'(e_hot), 32'(1) << me_k);
      check({req, " R8 even one-hot"}, 32'($countones(e_hot)), 32'd1);
      check({req, " odd stages"}, 32'(o_q), 32'(mo_q));
      check({req, " R7 odd decode"}, 32'(o_hot), 32'(1) << mo_k);
      check({req, " R8 odd one-hot"}, 32'($countones(o_hot)), 32'd1);
      check({req, " R6 no all-ones"}, 32'(o_q == 5'b11111), 32'd0);
   endtask

   task automatic tick(input logic r, input logic e);
      @(negedge clk);
      rst = r;
      count_en = e;
      @(posedge clk);
      #2;
      if (r) begin
         me_q = '0; me_k = 0; mo_q = '0; mo_k = 0;
      end else if (e) begin
         me_q = {~me_q[0], me_q[3:1]};
         me_k = (me_k + 1) % 8;
         mo_q = {~mo_q[0] & ~mo_q[1], mo_q[4:1]};
         mo_k = (mo_k + 1) % 9;
      end
   endtask

   task automatic t_reset();
      tick(1'b1, 1'b0);
      check_all("R1 reset");
   endtask

   task automatic t_walk();
      for (int n = 0; n < 18; n++) begin
         tick(1'b0, 1'b1);
         check_all("R4 R5 R6 walk");
         if (me_k == 0) check("R9 even wrap", 32'(e_q), 32'd0);
         if (mo_k == 0) check("R9 odd wrap", 32'(o_q), 32'd0);
      end
   endtask

   task automatic t_even_order();
      logic [3:0] seq [8] = '{4'b0000, 4'b1000, 4'b1100, 4'b1110, 4'b1111, 4'b0111, 4'b0011, 4'b0001};
      tick(1'b1, 1'b0);
      for (int n = 0; n < 8; n++) begin
         check("R5 even order", 32'(e_q), 32'(seq[n]));
         tick(1'b0, 1'b1);
      end
      check("R9 even back to zero", 32'(e_q), 32'd0);
   endtask

   task automatic t_hold();
      for (int n = 0; n < 3; n++) tick(1'b0, 1'b1);
      for (int n = 0; n < 4; n++) begin
         tick(1'b0, 1'b0);
         check_all("R3 hold");
      end
   endtask

   task automatic t_reset_vs_enable();
      for (int n = 0; n < 5; n++) tick(1'b0, 1'b1);
      tick(1'b1, 1'b1);
      check_all("R2 reset beats enable");
      check("R2 even cleared", 32'(e_q), 32'd0);
      tick(1'b0, 1'b1);
      check_all("R2 restart step one");
   endtask

   task automatic t_gapped();
      for (int n = 0; n < 20; n++) begin
         tick(1'b0, (n % 3) != 1);
         check_all("R3 R4 gapped enable");
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      me_q = '0; me_k = 0; mo_q = '0; mo_k = 0;
      t_reset();
      t_walk();
      t_even_order();
      t_hold();
      t_reset_vs_enable();
      t_gapped();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule